// File: doc/BRIEF.md
# Multi-Cycle Fetch-Execute Sequencer

This block is the control unit of a small register-file processor. It reads one 16-bit instruction at a time from a memory port into an instruction register and advances the program counter before it does anything else with the word. It then classifies the opcode, reads a memory operand only for the instructions that need one, and carries out the instruction as a short series of register transfers. Every access to memory and every ALU operation goes through a start/done handshake, so the sequencer always waits for the memory or the ALU to report completion.

Once an instruction is finished, a dedicated test step looks at the pending interrupt sources. These are an invalid-opcode fault, an ALU divide-by-zero flag and a set of external request lines. If a source is pending and interrupts are enabled, the sequencer saves the program counter into an exception register and jumps to a vector for that source. It also turns interrupts off and switches to system mode. The memory array and the ALU sit outside the block and answer on the two ports.

Handshake rules for both ports: the block raises `mem_start` or `alu_start` and keeps the address or operands steady until the clock edge at which the partner reports `done`. The partner can delay completion for as many cycles as it needs, and this is the only back-pressure. A `done` is taken as meaningful only while the matching start is high. Read data, the ALU result and the divide flag are sampled in the cycle in which `done` is high.

Top module: `seq_core`

## Requirements
- R1: While reset is held and just after it is released, `pc_o` and `epc_o` are 0, interrupts are enabled and the mode is user (`sys_mode_o`=0). The first access is an instruction read at address 0.
- R2: `mem_start` and `alu_start` stay high with a stable address or stable operands until the edge at which the matching `done` is seen.
- R3: When an instruction read completes, PC becomes the read address plus one. This happens before the instruction executes.
- R4: The instruction word is laid out as opcode in [15:12], register number in [11:9] and address/immediate in [8:0]. A second memory read, at the address field, is made only for opcode 1 (load) and opcode 2 (add).
- R5: Opcode 0 (jump) copies the address field into PC and makes no operand read and no ALU request.
- R6: Opcode 1 (load) writes the word read at the address field into the selected register.
- R7: Opcode 2 (add) presents the memory word on `alu_left` and the selected register on `alu_right` with `alu_func`=00. The result is written back to that register.
- R8: Opcode 3 (shift left) presents the selected register on `alu_left` and the zero-extended immediate on `alu_right` with `alu_func`=01. The result is written back.
- R9: Opcodes 4 to 11 do nothing. Opcodes 12 to 15 are invalid. They skip the operand and execute steps and raise interrupt source 0.
- R10: At interrupt entry, `epc_o` takes the PC (the address of the next instruction), PC takes 0x100 + 4 x source, interrupts are disabled and `sys_mode_o` is set.
- R11: Source 0 is the invalid opcode, source 1 is the ALU divide-by-zero flag, and source 2+k is `irq_req[k]`. When several are pending, the lowest-numbered source wins.
- R12: While interrupts are disabled, every pending source is ignored. An invalid opcode is then simply skipped, and execution continues at the next address.
- R13: The memory port and the ALU port are never requested in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_start | output | 1 | Memory read request, held until done |
| mem_addr | output | 9 | Word address of the read |
| mem_rdata | input | 16 | Read data, valid with mem_done |
| mem_done | input | 1 | Memory completion |
| alu_start | output | 1 | ALU request, held until done |
| alu_func | output | 2 | 00 add, 01 shift left |
| alu_left | output | 16 | Left ALU operand |
| alu_right | output | 16 | Right ALU operand |
| alu_result | input | 16 | ALU result, valid with alu_done |
| alu_done | input | 1 | ALU completion |
| alu_divz | input | 1 | Divide-by-zero flag, valid with alu_done |
| irq_req | input | 4 | External interrupt requests |
| pc_o | output | 9 | Program counter |
| epc_o | output | 9 | Saved PC of the last interrupt entry |
| irq_en_o | output | 1 | Interrupt enable |
| sys_mode_o | output | 1 | 1 = system mode |

## Verification
Some properties are checked on every cycle. These are the handshake hold rules, the rule that the two ports are never both requested, the PC increment after each instruction read, and the shape of an interrupt entry: the vector is aligned and within range, system mode is set, and interrupts stay off afterwards. Other behaviour shows up only in the bench's scenarios, because it depends on program content. This includes which instructions cause operand reads, the values that reach the ALU and the registers, the decision to skip or trap an invalid opcode, and how the priority between simultaneous sources is resolved. A recorded trace of memory addresses and ALU requests exposes all of it.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int OPC_W = 4;

  typedef enum logic [2:0] {
    K_NOP, K_JMP, K_LOD, K_ADD, K_LSH, K_BAD
  } kind_t;

  typedef enum logic [2:0] {
    S_FETCH, S_DECODE, S_OPRD, S_EXEC, S_ALU, S_ITEST
  } state_t;

  localparam logic [1:0] FN_ADD = 2'b00;
  localparam logic [1:0] FN_SHL = 2'b01;
endpackage

// File: rtl/seq_decoder.sv
module seq_decoder
  import seq_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  output kind_t            kind,
  output logic             needs_operand
);
  always_comb begin
    case (opcode)
      4'h0: kind = K_JMP;
      4'h1: kind = K_LOD;
      4'h2: kind = K_ADD;
      4'h3: kind = K_LSH;
      4'hC, 4'hD, 4'hE, 4'hF: kind = K_BAD;
      default: kind = K_NOP;
    endcase
  end

  assign needs_operand = (kind == K_LOD) || (kind == K_ADD);
endmodule

// File: rtl/seq_regfile.sv
module seq_regfile #(
  parameter int NREG = 8,
  parameter int DW   = 16,
  localparam int RW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [RW-1:0] rd_sel,
  output logic [DW-1:0] rd_data,
  input  logic          wr_en,
  input  logic [RW-1:0] wr_sel,
  input  logic [DW-1:0] wr_data
);
  logic [DW-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)
        regs[g] <= '0;
      else if (wr_en && (wr_sel == RW'(g)))
        regs[g] <= wr_data;
    end
  end

  assign rd_data = regs[rd_sel];
endmodule

// File: rtl/seq_irq_arb.sv
module seq_irq_arb #(
  parameter int          NSRC     = 6,
  parameter int          AW       = 9,
  parameter int unsigned VEC_BASE = 'h100,
  localparam int IW = $clog2(NSRC)
) (
  input  logic [NSRC-1:0] req,
  output logic            hit,
  output logic [AW-1:0]   vec
);
  logic [IW-1:0] idx;

  always_comb begin
    idx = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (req[i]) idx = IW'(i);
  end

  assign hit = |req;
  assign vec = AW'(VEC_BASE) + (AW'(idx) << 2);
endmodule

// File: rtl/seq_core.sv
module seq_core
  import seq_pkg::*;
#(
  parameter int          DW       = 16,
  parameter int          AW       = 9,
  parameter int          NREG     = 8,
  parameter int          NEXT     = 4,
  parameter int unsigned VEC_BASE = 'h100,
  localparam int RW   = $clog2(NREG),
  localparam int NSRC = NEXT + 2
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic            mem_start,
  output logic [AW-1:0]   mem_addr,
  input  logic [DW-1:0]   mem_rdata,
  input  logic            mem_done,
  output logic            alu_start,
  output logic [1:0]      alu_func,
  output logic [DW-1:0]   alu_left,
  output logic [DW-1:0]   alu_right,
  input  logic [DW-1:0]   alu_result,
  input  logic            alu_done,
  input  logic            alu_divz,
  input  logic [NEXT-1:0] irq_req,
  output logic [AW-1:0]   pc_o,
  output logic [AW-1:0]   epc_o,
  output logic            irq_en_o,
  output logic            sys_mode_o
);
  state_t        st;
  logic [DW-1:0] ir, mbr;
  logic [AW-1:0] pc, epc, mar;
  logic          int_en, sys_mode, flt_bad, flt_dz;

  kind_t         kind;
  logic          need_op;
  logic [RW-1:0] rsel;
  logic [AW-1:0] afield;
  logic [DW-1:0] rdat, wdat;
  logic          wen;
  logic          irq_hit;
  logic [AW-1:0] irq_vec;

  assign rsel   = ir[AW +: RW];
  assign afield = ir[AW-1:0];

  seq_decoder u_dec (
    .opcode        (ir[DW-1 -: OPC_W]),
    .kind          (kind),
    .needs_operand (need_op)
  );

  seq_regfile #(.NREG(NREG), .DW(DW)) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_sel  (rsel),
    .rd_data (rdat),
    .wr_en   (wen),
    .wr_sel  (rsel),
    .wr_data (wdat)
  );

  seq_irq_arb #(.NSRC(NSRC), .AW(AW), .VEC_BASE(VEC_BASE)) u_arb (
    .req ({irq_req, flt_dz, flt_bad}),
    .hit (irq_hit),
    .vec (irq_vec)
  );

  // memory and ALU port drive
  assign mem_start = (st == S_FETCH) || (st == S_OPRD);
  assign mem_addr  = (st == S_OPRD) ? mar : pc;
  assign alu_start = (st == S_ALU);
  assign alu_func  = (kind == K_ADD) ? FN_ADD : FN_SHL;
  assign alu_left  = (kind == K_ADD) ? mbr : rdat;
  assign alu_right = (kind == K_ADD) ? rdat : DW'(afield);

  // register write-back: load in execute, ALU ops on completion
  assign wen  = ((st == S_EXEC) && (kind == K_LOD)) ||
                ((st == S_ALU) && alu_done && !alu_divz);
  assign wdat = (kind == K_LOD) ? mbr : alu_result;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_FETCH;
      ir       <= '0;
      mbr      <= '0;
      mar      <= '0;
      pc       <= '0;
      epc      <= '0;
      int_en   <= 1'b1;
      sys_mode <= 1'b0;
      flt_bad  <= 1'b0;
      flt_dz   <= 1'b0;
    end else begin
      case (st)
        S_FETCH: if (mem_done) begin
          ir <= mem_rdata;
          pc <= pc + 1'b1;
          st <= S_DECODE;
        end
        S_DECODE: begin
          mar <= afield;
          if (kind == K_BAD) begin
            flt_bad <= 1'b1;
            st      <= S_ITEST;
          end else if (kind == K_NOP)
            st <= S_ITEST;
          else if (need_op)
            st <= S_OPRD;
          else
            st <= S_EXEC;
        end
        S_OPRD: if (mem_done) begin
          mbr <= mem_rdata;
          st  <= S_EXEC;
        end
        S_EXEC: begin
          if (kind == K_JMP) begin
            pc <= afield;
            st <= S_ITEST;
          end else if (kind == K_LOD)
            st <= S_ITEST;
          else
            st <= S_ALU;
        end
        S_ALU: if (alu_done) begin
          if (alu_divz) flt_dz <= 1'b1;
          st <= S_ITEST;
        end
        S_ITEST: begin
          flt_bad <= 1'b0;
          flt_dz  <= 1'b0;
          if (int_en && irq_hit) begin
            epc      <= pc;
            pc       <= irq_vec;
            int_en   <= 1'b0;
            sys_mode <= 1'b1;
          end
          st <= S_FETCH;
        end
        default: st <= S_FETCH;
      endcase
    end
  end

  assign pc_o       = pc;
  assign epc_o      = epc;
  assign irq_en_o   = int_en;
  assign sys_mode_o = sys_mode;
endmodule

// File: rtl/seq_core_chk.sv
module seq_core_chk
  import seq_pkg::*;
#(
  parameter int          DW       = 16,
  parameter int          AW       = 9,
  parameter int unsigned VEC_BASE = 'h100
) (
  input logic          clk,
  input logic          rst_n,
  input state_t        st,
  input logic          mem_start,
  input logic          mem_done,
  input logic [AW-1:0] mem_addr,
  input logic          alu_start,
  input logic          alu_done,
  input logic [DW-1:0] alu_left,
  input logic [DW-1:0] alu_right,
  input logic [AW-1:0] pc_o,
  input logic          irq_en_o,
  input logic          sys_mode_o
);
  // R2
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_start && !mem_done) |=> (mem_start && $stable(mem_addr)));

  // R2
  alu_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_start && !alu_done) |=> (alu_start && $stable(alu_left) && $stable(alu_right)));

  // R13
  one_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_start && alu_start));

  // R3
  pc_incr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == S_FETCH) && mem_done) |=> (pc_o == $past(mem_addr) + 1'b1));

  // R10
  entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_en_o) |-> (sys_mode_o && (pc_o[1:0] == 2'b00) && (pc_o >= AW'(VEC_BASE))));

  // R12
  stay_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en_o |=> !irq_en_o);
endmodule

bind seq_core seq_core_chk #(.DW(DW), .AW(AW), .VEC_BASE(VEC_BASE)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .st         (st),
  .mem_start  (mem_start),
  .mem_done   (mem_done),
  .mem_addr   (mem_addr),
  .alu_start  (alu_start),
  .alu_done   (alu_done),
  .alu_left   (alu_left),
  .alu_right  (alu_right),
  .pc_o       (pc_o),
  .irq_en_o   (irq_en_o),
  .sys_mode_o (sys_mode_o)
);

// File: tb/tb_seq_core.sv
`timescale 1ns/1ps
module tb_seq_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mem_start, mem_done;
  logic [8:0]  mem_addr;
  logic [15:0] mem_rdata;
  logic        alu_start, alu_done, alu_divz;
  logic [1:0]  alu_func;
  logic [15:0] alu_left, alu_right, alu_result;
  logic [3:0]  irq_req = 4'b0;
  logic [8:0]  pc_o, epc_o;
  logic        irq_en_o, sys_mode_o;

  always #4 clk = ~clk;

  seq_core dut (.*);

  // memory model: 2-cycle latency
  logic [15:0] mem [512];
  int          mcnt = 0;
  always @(posedge clk) begin
    if (mem_start && !mem_done && mcnt == 2) begin
      mem_done  <= 1'b1;
      mem_rdata <= mem[mem_addr];
      mcnt      <= 0;
    end else begin
      mem_done <= 1'b0;
      mcnt     <= (mem_start && !mem_done) ? mcnt + 1 : 0;
    end
  end

  // ALU model: 1-cycle latency
  logic dz_inject = 1'b0;
  int   acnt = 0;
  always @(posedge clk) begin
    if (alu_start && !alu_done && acnt == 1) begin
      alu_done   <= 1'b1;
      alu_divz   <= dz_inject;
      alu_result <= (alu_func == 2'b01) ? (alu_left << alu_right[3:0]) : (alu_left + alu_right);
      acnt       <= 0;
    end else begin
      alu_done <= 1'b0;
      alu_divz <= 1'b0;
      acnt     <= (alu_start && !alu_done) ? acnt + 1 : 0;
    end
  end

  // traces of completed memory reads and ALU requests
  logic [8:0]  ftr [64];
  logic [33:0] atr [64];
  int nf = 0, na = 0;
  always @(negedge clk) begin
    if (!rst_n) begin
      nf <= 0;
      na <= 0;
    end else begin
      if (mem_start && mem_done && nf < 64) begin
        ftr[nf] <= mem_addr;
        nf <= nf + 1;
      end
      if (alu_start && alu_done && na < 64) begin
        atr[na] <= {alu_func, alu_left, alu_right};
        na <= na + 1;
      end
    end
  end

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  task automatic chk(input string req, input logic [33:0] act, input logic [33:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] enc(input int op, input int r, input int f);
    return 16'((op << 12) | (r << 9) | f);
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 512; i++) mem[i] = 16'h0000;
  endtask

  // expected trace for program 1: every memory read address, in order
  localparam logic [8:0] EXP_F [16] = '{
    9'h000, 9'h040, 9'h001, 9'h041, 9'h002, 9'h003, 9'h042, 9'h004,
    9'h005, 9'h010, 9'h011, 9'h012, 9'h013, 9'h100, 9'h101, 9'h102};
  // expected ALU requests: {func, left, right}
  localparam logic [33:0] EXP_A [6] = '{
    {2'b00, 16'd5,      16'd3},
    {2'b01, 16'd8,      16'd2},
    {2'b01, 16'h8001,   16'd1},
    {2'b01, 16'd32,     16'd0},
    {2'b01, 16'd2,      16'd0},
    {2'b01, 16'd32,     16'd0}};
  localparam string REQ_F [16] = '{
    "R1", "R4", "R3", "R4", "R3", "R3", "R4", "R3",
    "R3", "R5", "R9", "R9", "R9", "R10", "R3", "R12"};
  localparam string REQ_A [6] = '{"R7", "R8", "R6", "R8", "R8", "R11"};

  initial begin
    clear_mem();
    // program 1
    mem[9'h000] = enc(1, 1, 'h40);  // load r1
    mem[9'h001] = enc(2, 1, 'h41);  // add r1
    mem[9'h002] = enc(3, 1, 2);     // shift r1 by 2
    mem[9'h003] = enc(1, 2, 'h42);  // load r2
    mem[9'h004] = enc(3, 2, 1);     // shift r2 by 1
    mem[9'h005] = enc(0, 0, 'h10);  // jump
    mem[9'h010] = enc(3, 1, 0);
    mem[9'h011] = enc(4, 0, 0);     // reserved no-op
    mem[9'h012] = enc(3, 2, 0);
    mem[9'h013] = enc(12, 0, 0);    // invalid, traps
    mem[9'h100] = enc(3, 1, 0);
    mem[9'h101] = enc(13, 0, 0);    // invalid, masked
    mem[9'h102] = enc(0, 0, 'h102);
    mem[9'h040] = 16'd3;
    mem[9'h041] = 16'd5;
    mem[9'h042] = 16'h8001;

    do_reset();
    #1;
    // R1 reset state
    chk("R1", 34'(pc_o), 34'h0);
    chk("R1", 34'(epc_o), 34'h0);
    chk("R1", 34'(irq_en_o), 34'h1);
    chk("R1", 34'(sys_mode_o), 34'h0);
    chk("R1", 34'({mem_start, mem_addr}), 34'h200);

    repeat (400) @(posedge clk);
    @(negedge clk);
    for (int i = 0; i < 16; i++) begin
      chk(REQ_F[i], 34'(ftr[i]), 34'(EXP_F[i]));
      if (i < 6) chk(REQ_A[i], atr[i], EXP_A[i]);
    end
    chk("R10", 34'(epc_o), 34'h14);
    chk("R10", 34'(sys_mode_o), 34'h1);
    chk("R10", 34'(irq_en_o), 34'h0);

    // divide-by-zero beats external line 0 (R11)
    clear_mem();
    mem[9'h000] = enc(3, 0, 1);
    mem[9'h104] = enc(0, 0, 'h104);
    mem[9'h108] = enc(0, 0, 'h108);
    dz_inject = 1'b1;
    irq_req   = 4'b0001;
    do_reset();
    repeat (150) @(posedge clk);
    @(negedge clk);
    chk("R11", 34'(ftr[1]), 34'h104);
    chk("R11", 34'(epc_o), 34'h1);
    chk("R10", 34'(sys_mode_o), 34'h1);
    dz_inject = 1'b0;

    // external lines 1 and 2 together: source 3 wins, no re-entry (R11, R12)
    clear_mem();
    mem[9'h000] = enc(0, 0, 'h20);
    mem[9'h10C] = enc(0, 0, 'h10C);
    mem[9'h110] = enc(0, 0, 'h110);
    irq_req = 4'b0110;
    do_reset();
    repeat (200) @(posedge clk);
    @(negedge clk);
    chk("R11", 34'(ftr[1]), 34'h10C);
    chk("R5", 34'(epc_o), 34'h20);
    chk("R12", 34'(ftr[2]), 34'h10C);
    chk("R12", 34'(ftr[4]), 34'h10C);
    chk("R5", 34'(na), 34'h0);
    irq_req = 4'b0;

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule